// File: doc/BRIEF.md
# Segment Table Address Translator

This block maps a 14-bit virtual address onto a physical address through a table of four segment descriptors held in flip-flops. The two upper address bits choose a descriptor. The twelve lower bits form an offset that is checked against the descriptor's length and then added to its base. A separate configuration port loads descriptors one at a time.

A lookup carries an address and an access direction, either read or write. One cycle later the block returns a response strobe together with either a translated address or a single fault code. The code says why the access was refused: no mapping, offset past the end, or a write into a descriptor without write permission. The block only classifies the access. Deciding what happens after a fault is left to the logic that receives the response.

Top module: `seg_xlate`

## Requirements
- R1: The segment number is `req_vaddr_i[13:12]` and the offset is `req_vaddr_i[11:0]`.
- R2: A cycle with `cfg_we_i` high loads base, length, mapped flag and write-enable into descriptor `cfg_idx_i`. The new contents apply to lookups issued in later cycles. A lookup of the same descriptor in that same cycle still sees the old contents.
- R3: After reset `rsp_valid_o` is 0 and all four descriptors are unmapped, so any lookup faults with code 1.
- R4: An access with no fault returns `rsp_fault_o` = 0 and `rsp_paddr_o` = (base + offset) modulo 2^16.
- R5: A lookup of a descriptor whose mapped flag is 0 returns fault code 1, for reads and for writes.
- R6: A mapped descriptor faults with code 2 when offset >= length. Length is 13 bits wide, so 0 refuses every offset and 4096 admits every offset.
- R7: A write (`req_write_i` = 1) to a descriptor whose write-enable is 0 returns fault code 3. Reads of such a descriptor are allowed.
- R8: Only one code is reported per access. Code 1 takes precedence over code 2, and code 2 takes precedence over code 3.
- R9: `rsp_valid_o` is high in exactly the cycle after each `req_valid_i` cycle. Whenever a fault is reported, and whenever `rsp_valid_o` is low, `rsp_paddr_o` is 0. Whenever `rsp_valid_o` is low, `rsp_fault_o` is also 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Descriptor load strobe |
| cfg_idx_i | input | 2 | Descriptor to load |
| cfg_base_i | input | 16 | Physical base address |
| cfg_len_i | input | 13 | Segment length in bytes (0 to 4096) |
| cfg_map_i | input | 1 | Mapped flag |
| cfg_wren_i | input | 1 | Write permission |
| req_valid_i | input | 1 | Lookup request |
| req_vaddr_i | input | 14 | Virtual address |
| req_write_i | input | 1 | 1 = write access, 0 = read access |
| rsp_valid_o | output | 1 | Response strobe |
| rsp_paddr_o | output | 16 | Translated address, 0 on fault |
| rsp_fault_o | output | 2 | 0 ok, 1 unmapped, 2 bounds, 3 write protect |

## Verification
The bench builds the block with its default parameters: 2 segment bits, a 12-bit offset and a 16-bit physical address. With only four descriptors, random traffic revisits every descriptor often, including in the same cycle as its reload. Because the physical address is narrow, a base near the top of the range makes the addition wrap. Because the length is 13 bits, the edge values 0 and 4096 can be driven directly and are checked alongside offsets just below and just at the length.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_UNMAP   = 2'd1,
    FLT_BOUNDS  = 2'd2,
    FLT_WRPROT  = 2'd3
  } fault_e;
endpackage

// File: rtl/seg_xlate_table.sv
module seg_xlate_table #(
  parameter int SEG_BITS = 2,
  parameter int PA_BITS  = 16,
  parameter int LEN_BITS = 13
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [SEG_BITS-1:0] wr_idx_i,
  input  logic [PA_BITS-1:0]  wr_base_i,
  input  logic [LEN_BITS-1:0] wr_len_i,
  input  logic                wr_map_i,
  input  logic                wr_wren_i,
  input  logic [SEG_BITS-1:0] rd_idx_i,
  output logic [PA_BITS-1:0]  rd_base_o,
  output logic [LEN_BITS-1:0] rd_len_o,
  output logic                rd_map_o,
  output logic                rd_wren_o
);
  localparam int NUM_SEG = 1 << SEG_BITS;

  logic [PA_BITS-1:0]  base_q [NUM_SEG];
  logic [LEN_BITS-1:0] len_q  [NUM_SEG];
  logic [NUM_SEG-1:0]  map_q;
  logic [NUM_SEG-1:0]  wren_q;

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_q[g] <= '0;
        len_q[g]  <= '0;
        map_q[g]  <= 1'b0;
        wren_q[g] <= 1'b0;
      end else if (we_i && wr_idx_i == SEG_BITS'(g)) begin
        base_q[g] <= wr_base_i;
        len_q[g]  <= wr_len_i;
        map_q[g]  <= wr_map_i;
        wren_q[g] <= wr_wren_i;
      end
    end
  end

  // read returns registered state: same-cycle load is not visible
  assign rd_base_o = base_q[rd_idx_i];
  assign rd_len_o  = len_q[rd_idx_i];
  assign rd_map_o  = map_q[rd_idx_i];
  assign rd_wren_o = wren_q[rd_idx_i];
endmodule

// File: rtl/seg_xlate_check.sv
module seg_xlate_check
  import seg_xlate_pkg::*;
#(
  parameter int OFF_BITS = 12,
  parameter int PA_BITS  = 16,
  parameter int LEN_BITS = OFF_BITS + 1
) (
  input  logic [OFF_BITS-1:0] offset_i,
  input  logic                write_i,
  input  logic [PA_BITS-1:0]  base_i,
  input  logic [LEN_BITS-1:0] len_i,
  input  logic                map_i,
  input  logic                wren_i,
  output fault_e              fault_o,
  output logic [PA_BITS-1:0]  paddr_o
);
  logic oob, wprot;

  // both tests evaluated in parallel, resolved by priority below
  assign oob   = {1'b0, offset_i} >= len_i;
  assign wprot = write_i && !wren_i;

  always_comb begin
    if (!map_i)     fault_o = FLT_UNMAP;
    else if (oob)   fault_o = FLT_BOUNDS;
    else if (wprot) fault_o = FLT_WRPROT;
    else            fault_o = FLT_NONE;
  end

  assign paddr_o = (fault_o == FLT_NONE) ? base_i + PA_BITS'(offset_i) : '0;
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int SEG_BITS = 2,
  parameter int OFF_BITS = 12,
  parameter int PA_BITS  = 16,
  localparam int VA_BITS  = SEG_BITS + OFF_BITS,
  localparam int LEN_BITS = OFF_BITS + 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_we_i,
  input  logic [SEG_BITS-1:0] cfg_idx_i,
  input  logic [PA_BITS-1:0]  cfg_base_i,
  input  logic [LEN_BITS-1:0] cfg_len_i,
  input  logic                cfg_map_i,
  input  logic                cfg_wren_i,
  input  logic                req_valid_i,
  input  logic [VA_BITS-1:0]  req_vaddr_i,
  input  logic                req_write_i,
  output logic                rsp_valid_o,
  output logic [PA_BITS-1:0]  rsp_paddr_o,
  output logic [1:0]          rsp_fault_o
);
  logic [SEG_BITS-1:0] seg;
  logic [OFF_BITS-1:0] off;
  logic [PA_BITS-1:0]  ent_base;
  logic [LEN_BITS-1:0] ent_len;
  logic                ent_map, ent_wren;
  fault_e              flt_d;
  logic [PA_BITS-1:0]  paddr_d;

  assign seg = req_vaddr_i[VA_BITS-1 -: SEG_BITS];
  assign off = req_vaddr_i[OFF_BITS-1:0];

  seg_xlate_table #(
    .SEG_BITS(SEG_BITS), .PA_BITS(PA_BITS), .LEN_BITS(LEN_BITS)
  ) table_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (cfg_we_i),
    .wr_idx_i  (cfg_idx_i),
    .wr_base_i (cfg_base_i),
    .wr_len_i  (cfg_len_i),
    .wr_map_i  (cfg_map_i),
    .wr_wren_i (cfg_wren_i),
    .rd_idx_i  (seg),
    .rd_base_o (ent_base),
    .rd_len_o  (ent_len),
    .rd_map_o  (ent_map),
    .rd_wren_o (ent_wren)
  );

  seg_xlate_check #(
    .OFF_BITS(OFF_BITS), .PA_BITS(PA_BITS), .LEN_BITS(LEN_BITS)
  ) check_i (
    .offset_i (off),
    .write_i  (req_write_i),
    .base_i   (ent_base),
    .len_i    (ent_len),
    .map_i    (ent_map),
    .wren_i   (ent_wren),
    .fault_o  (flt_d),
    .paddr_o  (paddr_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_paddr_o <= '0;
      rsp_fault_o <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_paddr_o <= req_valid_i ? paddr_d : '0;
      rsp_fault_o <= req_valid_i ? flt_d : FLT_NONE;
    end
  end
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int VA_BITS = 14,
  parameter int PA_BITS = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_valid_i,
  input logic               req_write_i,
  input logic [VA_BITS-1:0] req_vaddr_i,
  input logic               rsp_valid_o,
  input logic [PA_BITS-1:0] rsp_paddr_o,
  input logic [1:0]         rsp_fault_o
);
  AST_RSP_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);  // R9
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!rsp_valid_o && rsp_fault_o == 2'd0 && rsp_paddr_o == '0));  // R9
  AST_FAULT_NO_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o != 2'd0) |-> rsp_paddr_o == '0);  // R9
  AST_WRPROT_ONLY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !req_write_i |=> rsp_fault_o != 2'd3);  // R7
endmodule

bind seg_xlate seg_xlate_chk #(.VA_BITS(VA_BITS), .PA_BITS(PA_BITS)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_write_i (req_write_i),
  .req_vaddr_i (req_vaddr_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_paddr_o (rsp_paddr_o),
  .rsp_fault_o (rsp_fault_o)
);

// File: tb/seg_xlate_tb.sv
module seg_xlate_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        cfg_we_i;
  logic [1:0]  cfg_idx_i;
  logic [15:0] cfg_base_i;
  logic [12:0] cfg_len_i;
  logic        cfg_map_i, cfg_wren_i;
  logic        req_valid_i;
  logic [13:0] req_vaddr_i;
  logic        req_write_i;
  logic        rsp_valid_o;
  logic [15:0] rsp_paddr_o;
  logic [1:0]  rsp_fault_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [15:0] sh_base [4];
  logic [12:0] sh_len  [4];
  logic        sh_map  [4];
  logic        sh_wren [4];

  logic        exp_pend = 1'b0;
  logic [15:0] exp_paddr;
  logic [1:0]  exp_fault;
  string       exp_tag;

  always #2.5 clk_i = ~clk_i;
  always @(posedge clk_i) cycles++;

  seg_xlate dut_i (.*);

  initial begin
    wait (cycles > 100000);
    errors++;
    $display("FAIL watchdog: run hung, actual %0d cycles expected < 100000", cycles);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] model_fault(input logic [13:0] va, input logic wr);
    logic [1:0] s = va[13:12];
    if (!sh_map[s]) return 2'd1;
    if ({1'b0, va[11:0]} >= sh_len[s]) return 2'd2;
    if (wr && !sh_wren[s]) return 2'd3;
    return 2'd0;
  endfunction

  function automatic string fault_tag(input logic [1:0] f);
    case (f)
      2'd0: return "R1/R4";
      2'd1: return "R5";
      2'd2: return "R6";
      default: return "R7";
    endcase
  endfunction

  // one cycle: check the response for the previous request, then drive the next
  task automatic step(input logic we, input logic [1:0] idx, input logic [15:0] base,
                      input logic [12:0] len, input logic mp, input logic wen,
                      input logic rq, input logic [13:0] va, input logic wr,
                      input string tag);
    @(negedge clk_i);
    if (exp_pend) begin
      chk(rsp_valid_o === 1'b1, {exp_tag, " R9 valid"}, rsp_valid_o, 1);
      chk(rsp_fault_o === exp_fault, {exp_tag, " fault"}, rsp_fault_o, exp_fault);
      chk(rsp_paddr_o === exp_paddr, {exp_tag, " paddr"}, rsp_paddr_o, exp_paddr);
    end else begin
      chk(rsp_valid_o === 1'b0 && rsp_paddr_o === 16'd0 && rsp_fault_o === 2'd0,
          "R9 idle", {rsp_valid_o, rsp_fault_o, rsp_paddr_o}, 0);
    end
    cfg_we_i = we; cfg_idx_i = idx; cfg_base_i = base; cfg_len_i = len;
    cfg_map_i = mp; cfg_wren_i = wen;
    req_valid_i = rq; req_vaddr_i = va; req_write_i = wr;
    exp_pend = rq;
    if (rq) begin
      exp_fault = model_fault(va, wr);
      exp_paddr = (exp_fault == 2'd0) ? sh_base[va[13:12]] + 16'(va[11:0]) : 16'd0;
      exp_tag   = (tag == "") ? fault_tag(exp_fault) : tag;
    end
    // R2: shadow updated after the same-cycle lookup was modelled
    if (we) begin
      sh_base[idx] = base; sh_len[idx] = len; sh_map[idx] = mp; sh_wren[idx] = wen;
    end
  endtask

  task automatic load(input logic [1:0] idx, input logic [15:0] base,
                      input logic [12:0] len, input logic mp, input logic wen);
    step(1'b1, idx, base, len, mp, wen, 1'b0, 14'd0, 1'b0, "");
  endtask

  task automatic look(input logic [1:0] s, input logic [11:0] off, input logic wr,
                      input string tag);
    step(1'b0, 2'd0, 16'd0, 13'd0, 1'b0, 1'b0, 1'b1, {s, off}, wr, tag);
  endtask

  initial begin
    void'($urandom(32'h5e6a11));
    for (int i = 0; i < 4; i++) begin
      sh_base[i] = '0; sh_len[i] = '0; sh_map[i] = 1'b0; sh_wren[i] = 1'b0;
    end
    rst_ni = 1'b0;
    cfg_we_i = 0; cfg_idx_i = 0; cfg_base_i = 0; cfg_len_i = 0;
    cfg_map_i = 0; cfg_wren_i = 0; req_valid_i = 0; req_vaddr_i = 0; req_write_i = 0;
    repeat (3) @(negedge clk_i);
    chk(rsp_valid_o === 1'b0, "R3 reset valid", rsp_valid_o, 0);
    rst_ni = 1'b1;

    // R3: every descriptor unmapped after reset
    for (int s = 0; s < 4; s++) look(2'(s), 12'h000, 1'b0, "R3");

    load(2'd0, 16'h4000, 13'h700, 1'b1, 1'b0);  // read-only
    load(2'd1, 16'h0000, 13'h500, 1'b1, 1'b1);
    load(2'd3, 16'hFF00, 13'h1000, 1'b1, 1'b1); // full length, wraps
    look(2'd0, 12'h240, 1'b0, "R1 R4 read");
    look(2'd0, 12'h6FF, 1'b0, "R6 last byte ok");
    look(2'd0, 12'h700, 1'b0, "R6 at length");
    look(2'd0, 12'h100, 1'b1, "R7 write ro");
    look(2'd0, 12'hFFF, 1'b1, "R8 bounds over perm");
    look(2'd2, 12'hFFF, 1'b1, "R8 unmap first");
    look(2'd1, 12'h4FF, 1'b1, "R4 write ok");
    look(2'd3, 12'hFFF, 1'b1, "R6 len 4096 wrap");
    load(2'd1, 16'h1234, 13'h0, 1'b1, 1'b1);
    look(2'd1, 12'h000, 1'b0, "R6 len zero");
    // R2: same-cycle load and lookup sees old entry, next cycle sees new
    step(1'b1, 2'd0, 16'h8000, 13'h800, 1'b1, 1'b1, 1'b1, {2'd0, 12'h750}, 1'b1, "R2 old");
    look(2'd0, 12'h750, 1'b1, "R2 new");
    load(2'd0, 16'h8000, 13'h800, 1'b0, 1'b1);
    look(2'd0, 12'h010, 1'b0, "R5 unmapped");

    for (int n = 0; n < 3000; n++) begin
      logic [1:0]  s   = 2'($urandom_range(0, 3));
      logic [12:0] len = 13'($urandom_range(0, 4096));
      logic [11:0] off;
      if ($urandom_range(0, 3) == 0) len = ($urandom_range(0, 1) != 0) ? 13'd0 : 13'd4096;
      case ($urandom_range(0, 2))
        0: off = 12'(sh_len[s]);
        1: off = 12'(sh_len[s] - 13'd1);
        default: off = 12'($urandom);
      endcase
      step(1'($urandom_range(0, 4) == 0), 2'($urandom_range(0, 3)), 16'($urandom), len,
           1'($urandom_range(0, 5) != 0), 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 3) != 0), {s, off}, 1'($urandom_range(0, 1)), "");
    end
    step(1'b0, 2'd0, 16'd0, 13'd0, 1'b0, 1'b0, 1'b0, 14'd0, 1'b0, "");
    step(1'b0, 2'd0, 16'd0, 13'd0, 1'b0, 1'b0, 1'b0, 14'd0, 1'b0, "");

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule